// File: doc/BRIEF.md
# External Edge Capture and Counter Reset Unit

This block watches one external input for a chosen kind of transition and reacts to each one in one of two ways, chosen at run time. In capture mode it copies the current 24-bit value of a companion up-counter into a capture register. In reset mode it sends a one-cycle pulse that tells that counter to return to zero. The watched input is either a device pin or the output of an analog comparator, picked by a source-select bit. Both inputs are asynchronous, so the selected one passes through a two-flop synchroniser, and transitions are found by comparing successive synchronised samples.

Every detected transition sets an event flag, whatever the mode. Software clears the flag with a one-cycle clear strobe, which stands for writing 1 to the flag. An interrupt output is high while its enable bit and the flag are both high. The companion counter itself and any debounce filtering are outside the block.

Top module: `edge_capture_reset`

## Requirements
- R1: A change on the selected input reaches the outputs on the third rising clock edge after it was applied, and not before: two synchroniser edges, then the registered reaction.
- R2: With `edgeSel` = 2'b00, only 1-to-0 transitions of the synchronised input are detected.
- R3: With `edgeSel` = 2'b01, only 0-to-1 transitions are detected.
- R4: With `edgeSel` = 2'b10, both 0-to-1 and 1-to-0 transitions are detected.
- R5: With `edgeSel` = 2'b11 (reserved), no transition is detected.
- R6: While `funcEn` is 0, transitions set no flag, load no capture value and produce no reset pulse.
- R7: With `modeSel` = 0, a detected transition loads `countIn` into `capValue` and sets `extFlag` on the same clock edge. `capValue` holds its value otherwise.
- R8: With `modeSel` = 1, a detected transition makes `cntResetPulse` high for the cycle that follows it. It also sets `extFlag` and leaves `capValue` unchanged.
- R9: A high `flagClr` clears `extFlag` on the next clock edge. When a detection and a clear fall on the same edge, the flag ends up set.
- R10: `extIrq` is high exactly when `irqEn` and `extFlag` are both high.
- R11: `srcSel` = 0 watches `pinIn` and `srcSel` = 1 watches `cmpIn`. Transitions on the input that is not selected have no effect.
- R12: After reset, `capValue` is 0 and `extFlag`, `cntResetPulse` and `extIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | External pin, asynchronous |
| cmpIn | input | 1 | Analog comparator output, asynchronous |
| srcSel | input | 1 | Input source: 0 pin, 1 comparator |
| edgeSel | input | 2 | Transition kind: 00 fall, 01 rise, 10 both, 11 none |
| funcEn | input | 1 | Enables reaction to transitions |
| modeSel | input | 1 | 0 capture count, 1 reset counter |
| irqEn | input | 1 | Interrupt enable |
| flagClr | input | 1 | Clear strobe for the event flag (write-1 action) |
| countIn | input | 24 | Current value of the companion up-counter |
| capValue | output | 24 | Captured count |
| cntResetPulse | output | 1 | One-cycle request to zero the counter |
| extFlag | output | 1 | Event flag |
| extIrq | output | 1 | Interrupt request |

## Verification
Some internal faults only show up at the outputs. A synchroniser stage that is missing or doubled moves every flag, capture and reset pulse one cycle early or late. The bench compares all four outputs against a behavioural model on every clock, so such a fault fails on the first transition it affects. An edge decoder that confuses the kinds sets the flag on the wrong transition, and a capture strobe sent in the wrong mode changes `capValue` or pulses the reset line in the same cycle as the flag. Both are therefore seen one cycle after the synchronised transition.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edgeKind_e;

  typedef struct packed {
    logic setFlag;
    logic loadCap;
    logic rstCount;
  } ecrStrobe_t;

endpackage

// File: rtl/ecr_ctrl.sv
module ecr_ctrl
  import ecr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       cmpIn,
  input  logic       srcSel,
  input  logic [1:0] edgeSel,
  input  logic       funcEn,
  input  logic       modeSel,
  output ecrStrobe_t strobe
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic               selIn;
  logic [CHAIN_W-1:0] chainQ;
  logic               curSample;
  logic               prevSample;
  logic               hit;

  assign selIn = srcSel ? cmpIn : pinIn;

  // chainQ[SYNC_STAGES-1] is the last synchroniser stage, chainQ[SYNC_STAGES] its previous value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[CHAIN_W-2:0], selIn};
  end

  assign curSample  = chainQ[SYNC_STAGES-1];
  assign prevSample = chainQ[SYNC_STAGES];

  always_comb begin
    case (edgeKind_e'(edgeSel))
      EDGE_FALL: hit = prevSample & ~curSample;
      EDGE_RISE: hit = ~prevSample & curSample;
      EDGE_BOTH: hit = prevSample ^ curSample;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.setFlag  = funcEn & hit;
    strobe.loadCap  = funcEn & hit & ~modeSel;
    strobe.rstCount = funcEn & hit & modeSel;
  end

endmodule

// File: rtl/ecr_dpath.sv
module ecr_dpath
  import ecr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ecrStrobe_t       strobe,
  input  logic             flagClr,
  input  logic             irqEn,
  input  logic [CNT_W-1:0] countIn,
  output logic [CNT_W-1:0] capValue,
  output logic             extFlag,
  output logic             cntResetPulse,
  output logic             extIrq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capValue <= '0;
    else if (strobe.loadCap) capValue <= countIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               extFlag <= 1'b0;
    else if (strobe.setFlag) extFlag <= 1'b1;
    else if (flagClr)        extFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntResetPulse <= 1'b0;
    else       cntResetPulse <= strobe.rstCount;
  end

  assign extIrq = irqEn & extFlag;

endmodule

// File: rtl/edge_capture_reset.sv
module edge_capture_reset
  import ecr_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             cmpIn,
  input  logic             srcSel,
  input  logic [1:0]       edgeSel,
  input  logic             funcEn,
  input  logic             modeSel,
  input  logic             irqEn,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] countIn,
  output logic [CNT_W-1:0] capValue,
  output logic             cntResetPulse,
  output logic             extFlag,
  output logic             extIrq
);

  ecrStrobe_t strobe;

  ecr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .cmpIn  (cmpIn),
    .srcSel (srcSel),
    .edgeSel(edgeSel),
    .funcEn (funcEn),
    .modeSel(modeSel),
    .strobe (strobe)
  );

  ecr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .flagClr      (flagClr),
    .irqEn        (irqEn),
    .countIn      (countIn),
    .capValue     (capValue),
    .extFlag      (extFlag),
    .cntResetPulse(cntResetPulse),
    .extIrq       (extIrq)
  );

endmodule

// File: rtl/edge_capture_reset_chk.sv
module edge_capture_reset_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       edgeSel,
  input logic             funcEn,
  input logic             modeSel,
  input logic             irqEn,
  input logic             flagClr,
  input logic [CNT_W-1:0] capValue,
  input logic             cntResetPulse,
  input logic             extFlag,
  input logic             extIrq
);

  // R5: reserved code reacts to nothing
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'b11) |=> (!cntResetPulse && $stable(capValue)));

  // R6: disabled function reacts to nothing
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !funcEn |=> (!cntResetPulse && $stable(capValue)));

  // R7: capture only in capture mode, together with the flag
  a_r7_capture_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capValue) |-> (!$past(modeSel) && extFlag));

  // R8: reset pulse only in reset mode, together with the flag
  a_r8_pulse_in_reset_mode: assert property (@(posedge clk) disable iff (!rstN)
    cntResetPulse |-> ($past(modeSel) && extFlag));

  // R9: flag falls only after a clear request
  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extFlag) |-> $past(flagClr));

  // R10: interrupt needs flag and enable
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> (extFlag && irqEn));

endmodule

bind edge_capture_reset edge_capture_reset_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/edge_capture_reset_bench.sv
module edge_capture_reset_bench;

  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pinIn = 1'b0, cmpIn = 1'b0, srcSel = 1'b0;
  logic [1:0]       edgeSel = 2'b00;
  logic             funcEn = 1'b0, modeSel = 1'b0, irqEn = 1'b0, flagClr = 1'b0;
  logic [CNT_W-1:0] countIn = '0;
  logic [CNT_W-1:0] capValue;
  logic             cntResetPulse, extFlag, extIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  edge_capture_reset u_edge_capture_reset (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .srcSel(srcSel),
    .edgeSel(edgeSel), .funcEn(funcEn), .modeSel(modeSel), .irqEn(irqEn),
    .flagClr(flagClr), .countIn(countIn), .capValue(capValue),
    .cntResetPulse(cntResetPulse), .extFlag(extFlag), .extIrq(extIrq)
  );

  // behavioural reference: history of samples, newest first
  bit      hist[$] = '{0, 0, 0};
  int      mCap   = 0;
  bit      mFlag  = 0;
  bit      mPulse = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{0, 0, 0};
      mCap = 0; mFlag = 0; mPulse = 0;
    end else begin
      bit cur, prv, det, sel;
      cur = hist[1];
      prv = hist[2];
      case (edgeSel)
        2'd0:    det = prv && !cur;
        2'd1:    det = !prv && cur;
        2'd2:    det = prv != cur;
        default: det = 0;
      endcase
      det    = det && funcEn;
      mPulse = det && modeSel;
      if (det) mFlag = 1;
      else if (flagClr) mFlag = 0;
      if (det && !modeSel) mCap = int'(countIn);
      sel = srcSel ? cmpIn : pinIn;
      void'(hist.pop_back());
      hist.push_front(sel);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R7 capValue vs model", int'(capValue), mCap);
      chk("R8 cntResetPulse vs model", int'(cntResetPulse), int'(mPulse));
      chk("R9 extFlag vs model", int'(extFlag), int'(mFlag));
      chk("R10 extIrq vs model", int'(extIrq), int'(irqEn && mFlag));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; step(1); flagClr = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R12 reset capValue", int'(capValue), 0);
    chk("R12 reset extFlag", int'(extFlag), 0);
    chk("R12 reset cntResetPulse", int'(cntResetPulse), 0);
    chk("R12 reset extIrq", int'(extIrq), 0);
    rstN = 1'b1;
    step(2);

    // R3 rising, R1 latency, R7 capture
    funcEn = 1; modeSel = 0; edgeSel = 2'b01; srcSel = 0; countIn = 24'h123456;
    step(4);
    pinIn = 1; step(2);
    chk("R1 flag not yet set after two edges", int'(extFlag), 0);
    step(1);
    chk("R1 R3 flag set on third edge", int'(extFlag), 1);
    chk("R7 capture value", int'(capValue), 24'h123456);
    chk("R10 irq low while disabled", int'(extIrq), 0);
    irqEn = 1; step(1);
    chk("R10 irq high with flag and enable", int'(extIrq), 1);
    clearFlag(); step(1);
    chk("R9 flag cleared", int'(extFlag), 0);
    chk("R10 irq low after clear", int'(extIrq), 0);

    // R3: falling ignored in rise mode
    countIn = 24'h0000AA; pinIn = 0; step(4);
    chk("R3 falling ignored flag", int'(extFlag), 0);
    chk("R3 falling ignored cap", int'(capValue), 24'h123456);

    // R2 falling mode
    edgeSel = 2'b00; pinIn = 1; step(4);
    chk("R2 rising ignored", int'(extFlag), 0);
    countIn = 24'h00BEEF; pinIn = 0; step(4);
    chk("R2 falling flag", int'(extFlag), 1);
    chk("R2 falling cap", int'(capValue), 24'h00BEEF);
    clearFlag(); step(1);

    // R4 both
    edgeSel = 2'b10; countIn = 24'h000111; pinIn = 1; step(4);
    chk("R4 rise flag", int'(extFlag), 1);
    chk("R4 rise cap", int'(capValue), 24'h000111);
    clearFlag(); step(1);
    countIn = 24'h000222; pinIn = 0; step(4);
    chk("R4 fall flag", int'(extFlag), 1);
    chk("R4 fall cap", int'(capValue), 24'h000222);
    clearFlag(); step(1);

    // R5 reserved
    edgeSel = 2'b11; countIn = 24'h333333; pinIn = 1; step(4); pinIn = 0; step(4);
    chk("R5 reserved flag", int'(extFlag), 0);
    chk("R5 reserved cap", int'(capValue), 24'h000222);

    // R6 disabled
    funcEn = 0; edgeSel = 2'b10; pinIn = 1; step(3);
    chk("R6 disabled pulse", int'(cntResetPulse), 0);
    chk("R6 disabled flag", int'(extFlag), 0);
    chk("R6 disabled cap", int'(capValue), 24'h000222);
    step(1);

    // R8 reset mode
    funcEn = 1; modeSel = 1; edgeSel = 2'b01; pinIn = 0; step(4);
    countIn = 24'h777777; pinIn = 1; step(3);
    chk("R8 pulse high", int'(cntResetPulse), 1);
    chk("R8 flag set", int'(extFlag), 1);
    chk("R8 cap unchanged", int'(capValue), 24'h000222);
    step(1);
    chk("R8 pulse one cycle", int'(cntResetPulse), 0);
    clearFlag(); step(1);

    // R11 source select
    modeSel = 0; edgeSel = 2'b10; cmpIn = 1; step(1); srcSel = 1; step(4);
    chk("R11 switch with equal levels", int'(extFlag), 0);
    pinIn = 0; step(4);
    chk("R11 unselected pin ignored", int'(extFlag), 0);
    countIn = 24'h0ABCDE; cmpIn = 0; step(4);
    chk("R11 comparator flag", int'(extFlag), 1);
    chk("R11 comparator cap", int'(capValue), 24'h0ABCDE);
    clearFlag(); step(1);

    // R9 set wins over clear
    edgeSel = 2'b01; cmpIn = 1; step(2);
    flagClr = 1; step(1); flagClr = 0;
    chk("R9 set wins over clear", int'(extFlag), 1);
    clearFlag(); step(1);

    // random phase, checked against the model each clock
    for (int i = 0; i < 3000; i++) begin
      pinIn   = 1'($urandom);
      cmpIn   = 1'($urandom);
      if ($urandom_range(0, 15) == 0) srcSel = 1'($urandom);
      if ($urandom_range(0, 15) == 0) edgeSel = 2'($urandom);
      funcEn  = ($urandom_range(0, 7) != 0);
      modeSel = 1'($urandom);
      irqEn   = 1'($urandom);
      flagClr = ($urandom_range(0, 5) == 0);
      countIn = 24'($urandom);
      step(1);
    end
    flagClr = 0;
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule